// File: doc/BRIEF.md
# Companded Sample Expander with Error Concealment

This block sits behind a de-interleaver in a digital audio receive path. Each incoming word holds a 10-bit two's-complement compressed sample and one parity bit. It comes with a 3-bit scale code that is shared across its block and with a channel index. The expander sign-extends the sample to 14 bits and shifts it left by an amount that the scale code selects. It also checks the word's parity. The 14-bit result appears one clock later with a valid strobe.

When a word fails its parity check, the block does not pass on the corrupted value. It repeats the last error-free sample seen on the same channel and raises a one-cycle error pulse alongside it. Each channel keeps its own last-good value. Both values reset to zero.

Top module: `cexp_top`

## Requirements
- R1: While reset is asserted and after it is released, with no words sent, `sample_o` is 0 and `valid_o` and `err_o` are 0.
- R2: `valid_o` is high in exactly the cycle after a cycle with `valid_i` high, and low otherwise.
- R3: Word bit 10 is the parity bit. A word is error-free when bits 10 down to 4 hold an even number of ones. The state of bits 3..0 has no effect on this check.
- R4: For an error-free word with scale code c in 0..4, `sample_o` equals word bits 9..0, read as a signed value, multiplied by 2^c. The result is a 14-bit two's-complement value.
- R5: Scale codes 5, 6 and 7 each shift by 4, the same as code 4.
- R6: For a word in error, `sample_o` repeats the last error-free output of the same channel, and `err_o` is high in that same cycle.
- R7: Channel 0 (`chan_i`=0) and channel 1 (`chan_i`=1) each keep their own last-good sample. Traffic on one channel never changes the other channel's stored value.
- R8: A word in error on a channel that has had no error-free word since reset outputs 0.
- R9: `err_o` is never high without `valid_o`.
- R10: Cycles with `valid_i` low have no effect: `sample_o` holds its value and the stored last-good samples stay unchanged, whatever is on `word_i`, `scale_i` and `chan_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word strobe |
| word_i | input | 11 | Bit 10 parity, bits 9..0 signed compressed sample |
| scale_i | input | 3 | Scale code selecting the left shift |
| chan_i | input | 1 | Channel index |
| sample_o | output | 14 | Expanded or concealed sample |
| valid_o | output | 1 | Output strobe, one cycle after `valid_i` |
| err_o | output | 1 | High with a concealed sample |

## Verification
The assertions check on every cycle:
- the one-cycle strobe latency;
- that an error pulse never appears without a valid strobe;
- that the parity verdict decides whether an error pulse follows;
- that a concealed sample equals the stored value;
- that the store changes only on error-free writes and that `sample_o` holds while idle;
- that the expansion is exact, by shifting the output back arithmetically.

Only the bench scenarios can show the actual numeric values. These include the mapping of every scale code, including the clamped codes, the per-channel separation of the concealment history, the zero output for an error on a fresh channel, and long runs of back-to-back words.

// File: rtl/cexp_pkg.sv
package cexp_pkg;
  localparam int unsigned DATA_W = 10;
  localparam int unsigned OUT_W  = 14;
  localparam int unsigned SF_W   = 3;
  localparam int unsigned PAR_W  = 6;
  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/cexp_parity.sv
module cexp_parity #(
  parameter int unsigned PAR_W = cexp_pkg::PAR_W
) (
  input  logic [PAR_W:0] par_i,  // parity bit on top, covered data bits below
  output logic           ok_o
);
  // even parity across covered bits plus parity bit
  assign ok_o = ~(^par_i);
endmodule

// File: rtl/cexp_expand.sv
module cexp_expand #(
  parameter int unsigned DATA_W = cexp_pkg::DATA_W,
  parameter int unsigned OUT_W  = cexp_pkg::OUT_W,
  parameter int unsigned SF_W   = cexp_pkg::SF_W
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [SF_W-1:0]   scale_i,
  output logic [OUT_W-1:0]  samp_o
);
  localparam int unsigned MAX_SHIFT = OUT_W - DATA_W;

  logic [OUT_W-1:0] sext;
  logic [SF_W-1:0]  shift_sel;
  logic [OUT_W-1:0] cand [MAX_SHIFT+1];

  assign sext      = {{(OUT_W-DATA_W){data_i[DATA_W-1]}}, data_i};
  // codes above the largest lossless shift saturate
  assign shift_sel = (scale_i > SF_W'(MAX_SHIFT)) ? SF_W'(MAX_SHIFT) : scale_i;

  for (genvar g = 0; g <= MAX_SHIFT; g++) begin : g_cand
    assign cand[g] = sext << g;
  end

  always_comb begin
    samp_o = cand[0];
    for (int s = 0; s <= MAX_SHIFT; s++) begin
      if (shift_sel == SF_W'(s)) samp_o = cand[s];
    end
  end

  always_comb begin
    if (!$isunknown({data_i, scale_i}))
      AST_EXPAND_INVERT: assert (($signed(samp_o) >>> shift_sel) == $signed(sext)); // R4
  end
endmodule

// File: rtl/cexp_store.sv
module cexp_store #(
  parameter int unsigned OUT_W  = cexp_pkg::OUT_W,
  parameter int unsigned NUM_CH = cexp_pkg::NUM_CH,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CH_W-1:0]  ch_i,
  input  logic [OUT_W-1:0] d_i,
  output logic [OUT_W-1:0] rd_o
);
  logic [NUM_CH-1:0][OUT_W-1:0] mem_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[c] <= '0;
      else if (wr_i && ch_i == CH_W'(c))    mem_q[c] <= d_i;
    end
  end

  assign rd_o = mem_q[ch_i];

  AST_STORE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(mem_q)); // R10
  AST_STORE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> mem_q[$past(ch_i)] == $past(d_i)); // R7
endmodule

// File: rtl/cexp_top.sv
module cexp_top #(
  parameter int unsigned DATA_W = cexp_pkg::DATA_W,
  parameter int unsigned OUT_W  = cexp_pkg::OUT_W,
  parameter int unsigned SF_W   = cexp_pkg::SF_W,
  parameter int unsigned PAR_W  = cexp_pkg::PAR_W,
  parameter int unsigned NUM_CH = cexp_pkg::NUM_CH,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W:0]   word_i,
  input  logic [SF_W-1:0]   scale_i,
  input  logic [CH_W-1:0]   chan_i,
  output logic [OUT_W-1:0]  sample_o,
  output logic              valid_o,
  output logic              err_o
);
  logic             par_ok;
  logic [OUT_W-1:0] exp_samp;
  logic [OUT_W-1:0] last_good;
  logic             good_wr;

  cexp_parity #(.PAR_W(PAR_W)) u_par (
    .par_i (word_i[DATA_W -: PAR_W+1]),
    .ok_o  (par_ok)
  );

  cexp_expand #(.DATA_W(DATA_W), .OUT_W(OUT_W), .SF_W(SF_W)) u_exp (
    .data_i  (word_i[DATA_W-1:0]),
    .scale_i (scale_i),
    .samp_o  (exp_samp)
  );

  assign good_wr = valid_i & par_ok;

  cexp_store #(.OUT_W(OUT_W), .NUM_CH(NUM_CH)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (good_wr),
    .ch_i   (chan_i),
    .d_i    (exp_samp),
    .rd_o   (last_good)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o <= '0;
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      err_o   <= valid_i & ~par_ok;
      if (valid_i) sample_o <= par_ok ? exp_samp : last_good;
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R2
  AST_ERR_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> valid_o); // R9
  AST_BAD_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !par_ok |=> err_o); // R6
  AST_GOOD_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && par_ok |=> !err_o); // R3
  AST_CONCEAL_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !par_ok |=> sample_o == $past(last_good)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(sample_o)); // R10
endmodule

// File: tb/cexp_top_test.sv
`timescale 1ns/1ps
module cexp_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [10:0] word_i = '0;
  logic [2:0]  scale_i = '0;
  logic        chan_i = 1'b0;
  logic [13:0] sample_o;
  logic        valid_o;
  logic        err_o;

  int checks = 0;
  int fails  = 0;
  logic [13:0] lg [2];

  always #10 clk = ~clk;

  cexp_top uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .word_i(word_i),
    .scale_i(scale_i), .chan_i(chan_i), .sample_o(sample_o),
    .valid_o(valid_o), .err_o(err_o)
  );

  task automatic chk(input logic [13:0] act, input logic [13:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] mk_word(input logic [9:0] d, input bit bad);
    logic p;
    p = ^d[9:4];
    return {p ^ bad, d};
  endfunction

  function automatic logic [13:0] expect_val(input logic [9:0] d, input logic [2:0] sf);
    int v;
    int sh;
    sh = (sf > 3'd4) ? 4 : int'(sf);
    v  = int'($signed(d));
    v  = v * (1 << sh);
    return v[13:0];
  endfunction

  // drive one word; result checked one cycle later at the next falling edge
  task automatic send(input logic [9:0] d, input bit bad, input logic [2:0] sf,
                      input bit ch, input string req);
    logic [13:0] exp;
    @(negedge clk);
    valid_i = 1'b1; word_i = mk_word(d, bad); scale_i = sf; chan_i = ch;
    if (bad) exp = lg[ch];
    else begin exp = expect_val(d, sf); lg[ch] = exp; end
    @(negedge clk);
    chk(sample_o, exp, req);
    chk({13'd0, valid_o}, 14'd1, {req, " valid"});
    chk({13'd0, err_o}, {13'd0, bad}, {req, " err"});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      word_i = 11'(i * 37 + 5); scale_i = 3'(i); chan_i = 1'(i);
    end
  endtask

  task automatic t_reset;
    chk(sample_o, 14'd0, "R1 sample during reset");
    chk({12'd0, valid_o, err_o}, 14'd0, "R1 strobes during reset");
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    @(negedge clk);
    chk(sample_o, 14'd0, "R1 sample after reset");
    chk({12'd0, valid_o, err_o}, 14'd0, "R1 strobes after reset");
  endtask

  task automatic t_fresh_error;
    send(10'h155, 1'b1, 3'd2, 1'b0, "R8 ch0 fresh error");
    send(10'h0AA, 1'b1, 3'd4, 1'b1, "R8 ch1 fresh error");
    idle(1);
  endtask

  task automatic t_shifts;
    for (int sf = 0; sf < 5; sf++) begin
      send(10'h1FF, 1'b0, 3'(sf), 1'b0, "R4 max positive");
      send(10'h200, 1'b0, 3'(sf), 1'b0, "R4 max negative");
      send(10'h3FF, 1'b0, 3'(sf), 1'b1, "R4 minus one");
    end
    idle(1);
  endtask

  task automatic t_clamp;
    for (int sf = 5; sf < 8; sf++) begin
      send(10'h123, 1'b0, 3'(sf), 1'b0, "R5 clamp positive");
      send(10'h2C7, 1'b0, 3'(sf), 1'b1, "R5 clamp negative");
    end
    idle(1);
  endtask

  task automatic t_parity;
    // low four bits outside coverage: correct parity bit keeps word clean
    send(10'h00F, 1'b0, 3'd0, 1'b0, "R3 low bits uncovered");
    send(10'h3F0, 1'b0, 3'd1, 1'b0, "R3 all covered ones");
    send(10'h3F0, 1'b1, 3'd1, 1'b0, "R3 parity bit wrong");
    send(10'h010, 1'b1, 3'd3, 1'b0, "R3 single covered bit");
    idle(1);
  endtask

  task automatic t_conceal;
    send(10'h07B, 1'b0, 3'd2, 1'b0, "R7 ch0 good");
    send(10'h301, 1'b0, 3'd3, 1'b1, "R7 ch1 good");
    send(10'h1AA, 1'b1, 3'd0, 1'b0, "R6 ch0 concealed");
    send(10'h055, 1'b1, 3'd4, 1'b1, "R6 ch1 concealed");
    send(10'h055, 1'b1, 3'd4, 1'b1, "R6 ch1 repeated error");
    send(10'h011, 1'b0, 3'd1, 1'b1, "R7 ch1 update");
    send(10'h2AA, 1'b1, 3'd2, 1'b0, "R7 ch0 untouched");
    idle(1);
  endtask

  task automatic t_idle;
    logic [13:0] held;
    send(10'h0C3, 1'b0, 3'd1, 1'b0, "R2 single word");
    held = sample_o;
    idle(1);
    @(negedge clk);
    chk({13'd0, valid_o}, 14'd0, "R2 strobe drops");
    chk({13'd0, err_o}, 14'd0, "R9 no error while idle");
    idle(4);
    @(negedge clk);
    chk(sample_o, held, "R10 sample held while idle");
    send(10'h3C3, 1'b1, 3'd0, 1'b0, "R10 store unchanged by idle inputs");
    send(10'h3C3, 1'b1, 3'd0, 1'b1, "R10 ch1 store unchanged");
    idle(1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    lg[0] = '0; lg[1] = '0;
    repeat (2) @(negedge clk);
    t_reset();
    t_fresh_error();
    t_shifts();
    t_clamp();
    t_parity();
    t_conceal();
    t_idle();
    idle(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule